// File: doc/BRIEF.md
# Reorder Buffer with Deferred Faults

This block keeps the program order of in-flight micro-ops for an out-of-order core. Each cycle a dispatch group of up to `DISP_W` micro-ops (4 by default, 6 also supported) is written at the tail of a circular buffer. Every entry records its architectural destination, the physical tag its result lands in, whether it has finished, and whether it faulted together with a fault code. Execution units finish out of order and report through completion ports. A completion writes only the hidden physical register file and marks the entry done; the architectural register file is left alone.

Entries leave strictly from the head, in order. Retiring an entry copies its physical register into its architectural register, which undoes the rename. A fault seen during execution is only stored in the entry. When that entry becomes the oldest, the block raises a precise exception carrying its index and code. It then discards that entry and everything younger without committing any of them. A branch mispredict input names a buffer slot and cuts the buffer back to just after it in a single cycle.

Top module: `rob_top`

## Requirements
- R1: After reset the buffer is empty. `dispReady` is 1 for any `dispCount` up to `DISP_W`, `excValid` and `retCount` are 0, and every architectural register reads 0.
- R2: An accepted group of `dispCount` micro-ops fills consecutive slots, starting at the slot shown on `allocIdx` in the accepting cycle. Slot numbers wrap modulo `DEPTH`.
- R3: `dispReady` is 0 when fewer free slots remain than `dispCount`. A group presented while `dispReady` is 0 is not stored, so the buffer never holds more than `DEPTH` entries.
- R4: A completion writes only the physical register file. The architectural register of an entry keeps its old value until that entry retires.
- R5: Retirement is in program order. A head entry that has not completed blocks retirement of every younger entry, even completed ones.
- R6: Up to `DISP_W` completed, non-faulting entries at the head retire in one cycle. `retCount` shows, one cycle later, how many retired, and the architectural file holds their results from then on.
- R7: A faulting completion raises nothing while older entries are still present. Retirement stops just before the faulting entry. The cycle after that entry is at the head and done, `excValid` pulses for one cycle with `excIdx` equal to its slot and `excCode` equal to its code. Neither it nor any younger entry is committed, and the buffer is empty afterwards, with `allocIdx` equal to the faulting slot.
- R8: A mispredict at slot M discards every entry younger than M and moves the tail to M+1 in the same cycle. Completions aimed at discarded entries are ignored, and discarded entries never commit.
- R9: A dispatch group presented in the same cycle as a mispredict is dropped.
- R10: When several entries retiring in one cycle share an architectural destination, the youngest of them leaves its value.
- R11: All completion ports are served in the same cycle when they name different entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dispCount | input | $clog2(DISP_W+1) | Number of micro-ops offered this cycle (0 = none) |
| dispArch | input | DISP_W x $clog2(ARCH_REGS) | Architectural destination per group lane |
| dispPtag | input | DISP_W x $clog2(PHYS_REGS) | Physical tag per group lane |
| dispReady | output | 1 | Enough free slots for `dispCount` |
| allocIdx | output | $clog2(DEPTH) | Slot that lane 0 of an accepted group takes |
| cplValid | input | CPL_N | Completion strobe per port |
| cplIdx | input | CPL_N x $clog2(DEPTH) | Slot completed per port |
| cplData | input | CPL_N x DATA_W | Result per port |
| cplFault | input | CPL_N | Fault flag per port |
| cplCode | input | CPL_N x FAULT_W | Fault code per port |
| mispValid | input | 1 | Branch mispredict strobe |
| mispIdx | input | $clog2(DEPTH) | Slot of the mispredicted branch |
| retCount | output | $clog2(DISP_W+1) | Entries retired in the previous cycle |
| excValid | output | 1 | Precise exception pulse |
| excIdx | output | $clog2(DEPTH) | Slot of the faulting entry |
| excCode | output | FAULT_W | Fault code of that entry |
| archRdAddr | input | $clog2(ARCH_REGS) | Architectural register read address |
| archRdData | output | DATA_W | Architectural register contents (combinational) |

## Verification
Head and tail pointers that drift apart show up at once as a wrong `allocIdx` or a wrong `dispReady` on the next offered group. A lost or extra done bit shows as a `retCount` that is off in the cycle after the head should retire. A completion that leaks into the architectural file, or a squashed entry that commits, becomes visible on `archRdData` right after the edge where it wrongly lands. A mistimed fault shows as an `excValid` pulse one cycle early or late, or as a register that the faulting entry should have left untouched.

// File: rtl/rob_pkg.sv
package rob_pkg;

  // control-to-datapath strobes for one cycle
  typedef struct packed {
    logic alloc;   // a dispatch group is written this cycle
    logic flush;   // faulting head: drop everything
    logic squash;  // mispredict: drop entries past the branch
  } robStrobe_t;

  // outcome of the head inspection in a cycle
  typedef enum logic [1:0] {
    HEAD_IDLE   = 2'd0,
    HEAD_COMMIT = 2'd1,
    HEAD_FAULT  = 2'd2
  } headOutcome_t;

endpackage

// File: rtl/rob_ctrl.sv
module rob_ctrl
  import rob_pkg::*;
#(
  parameter int DISP_W  = 4,
  parameter int DEPTH   = 16,
  parameter int FAULT_W = 4,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = $clog2(DISP_W + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [CW-1:0]      dispCount,
  input  logic               mispValid,
  input  logic [IW-1:0]      mispIdx,
  input  logic [DEPTH-1:0]   entValid,
  input  logic [DEPTH-1:0]   entDone,
  input  logic [DEPTH-1:0]   entFault,
  input  logic [FAULT_W-1:0] headCode,
  output robStrobe_t         strobe,
  output logic [IW-1:0]      allocBase,
  output logic [CW-1:0]      allocCnt,
  output logic [CW-1:0]      retireCnt,
  output logic [IW-1:0]      headIdx,
  output logic [DEPTH-1:0]   killMask,
  output logic               dispReady,
  output logic [CW-1:0]      retCountQ,
  output logic               excValidQ,
  output logic [IW-1:0]      excIdxQ,
  output logic [FAULT_W-1:0] excCodeQ
);

  // pointers carry one wrap bit above the slot index
  logic [IW:0] headPtr, tailPtr;
  logic [IW:0] occ, freeCnt;
  logic [IW-1:0] mispOff;
  logic excFire, mispEff, dispAcc;
  logic [CW-1:0] retCnt;
  headOutcome_t outcome;

  assign headIdx   = headPtr[IW-1:0];
  assign allocBase = tailPtr[IW-1:0];
  assign occ       = tailPtr - headPtr;
  assign freeCnt   = (IW+1)'(DEPTH) - occ;
  assign dispReady = int'(freeCnt) >= int'(dispCount);
  assign mispOff   = mispIdx - headIdx;

  // head inspection: fault at the oldest entry, else a run of finished entries
  always_comb begin
    logic run;
    logic [IW-1:0] slot;
    excFire = (occ != '0) && entDone[headIdx] && entFault[headIdx];
    run     = 1'b1;
    retCnt  = '0;
    for (int k = 0; k < DISP_W; k++) begin
      slot = headIdx + IW'(k);
      if (run && (k < int'(occ)) && entDone[slot] && !entFault[slot] &&
          (!mispValid || k <= int'(mispOff)))
        retCnt = retCnt + CW'(1);
      else
        run = 1'b0;
    end
    if (excFire) outcome = HEAD_FAULT;
    else if (retCnt != '0) outcome = HEAD_COMMIT;
    else outcome = HEAD_IDLE;
  end

  assign mispEff = mispValid && (outcome != HEAD_FAULT);
  assign dispAcc = (dispCount != '0) && dispReady && !mispValid && (outcome != HEAD_FAULT);

  // entries to drop: all on a fault, those past the branch on a mispredict
  always_comb begin
    logic [IW-1:0] off;
    for (int i = 0; i < DEPTH; i++) begin
      off = IW'(i) - headIdx;
      if (outcome == HEAD_FAULT)
        killMask[i] = 1'b1;
      else
        killMask[i] = mispEff && (off > mispOff) && (int'(off) < int'(occ));
    end
  end

  assign retireCnt     = (outcome == HEAD_COMMIT) ? retCnt : '0;
  assign allocCnt      = dispAcc ? dispCount : '0;
  assign strobe.alloc  = dispAcc;
  assign strobe.flush  = (outcome == HEAD_FAULT);
  assign strobe.squash = mispEff;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headPtr   <= '0;
      tailPtr   <= '0;
      retCountQ <= '0;
      excValidQ <= 1'b0;
      excIdxQ   <= '0;
      excCodeQ  <= '0;
    end else begin
      headPtr <= headPtr + (IW+1)'(retireCnt);
      if (outcome == HEAD_FAULT)
        tailPtr <= headPtr;
      else if (mispEff)
        tailPtr <= headPtr + {1'b0, mispOff} + (IW+1)'(1);
      else if (dispAcc)
        tailPtr <= tailPtr + (IW+1)'(dispCount);
      retCountQ <= retireCnt;
      excValidQ <= (outcome == HEAD_FAULT);
      excIdxQ   <= headIdx;
      excCodeQ  <= headCode;
    end
  end

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    int'(occ) <= DEPTH);

  // R7
  exc_empties_chk: assert property (@(posedge clk) disable iff (!rstN)
    excValidQ |-> (tailPtr == headPtr));

  // R7
  exc_no_retire_chk: assert property (@(posedge clk) disable iff (!rstN)
    excValidQ |-> (retCountQ == '0));

  // R5
  head_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (occ != '0) |-> entValid[headIdx]);

  // R5
  retire_head_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (retCountQ != '0) |-> $past(entDone[headIdx]));

endmodule

// File: rtl/rob_data.sv
module rob_data
  import rob_pkg::*;
#(
  parameter int DISP_W    = 4,
  parameter int DEPTH     = 16,
  parameter int ARCH_REGS = 16,
  parameter int PHYS_REGS = 32,
  parameter int DATA_W    = 32,
  parameter int FAULT_W   = 4,
  parameter int CPL_N     = 2,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = $clog2(DISP_W + 1),
  localparam int AW = $clog2(ARCH_REGS),
  localparam int PW = $clog2(PHYS_REGS)
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  robStrobe_t                     strobe,
  input  logic [IW-1:0]                  allocBase,
  input  logic [CW-1:0]                  allocCnt,
  input  logic [DISP_W-1:0][AW-1:0]      dispArch,
  input  logic [DISP_W-1:0][PW-1:0]      dispPtag,
  input  logic [CW-1:0]                  retireCnt,
  input  logic [IW-1:0]                  headIdx,
  input  logic [DEPTH-1:0]               killMask,
  input  logic [CPL_N-1:0]               cplValid,
  input  logic [CPL_N-1:0][IW-1:0]       cplIdx,
  input  logic [CPL_N-1:0][DATA_W-1:0]   cplData,
  input  logic [CPL_N-1:0]               cplFault,
  input  logic [CPL_N-1:0][FAULT_W-1:0]  cplCode,
  input  logic [AW-1:0]                  archRdAddr,
  output logic [DATA_W-1:0]              archRdData,
  output logic [DEPTH-1:0]               entValid,
  output logic [DEPTH-1:0]               entDone,
  output logic [DEPTH-1:0]               entFault,
  output logic [FAULT_W-1:0]             headCode
);

  logic [DEPTH-1:0][AW-1:0]      archQ;
  logic [DEPTH-1:0][PW-1:0]      ptagQ;
  logic [DEPTH-1:0][FAULT_W-1:0] codeQ;
  logic [PHYS_REGS-1:0][DATA_W-1:0] physRf;
  logic [ARCH_REGS-1:0][DATA_W-1:0] archRf;

  logic [DISP_W-1:0][IW-1:0] allocSlot;
  logic [DISP_W-1:0][IW-1:0] retSlot;

  genvar g;
  generate
    for (g = 0; g < DISP_W; g++) begin : g_lane
      assign allocSlot[g] = allocBase + IW'(g);
      assign retSlot[g]   = headIdx + IW'(g);
    end
  endgenerate

  assign archRdData = archRf[archRdAddr];
  assign headCode   = codeQ[headIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      entValid <= '0;
      entDone  <= '0;
      entFault <= '0;
      archQ    <= '0;
      ptagQ    <= '0;
      codeQ    <= '0;
      physRf   <= '0;
      archRf   <= '0;
    end else begin
      // completion: hidden register file and entry status only
      for (int c = 0; c < CPL_N; c++) begin
        if (cplValid[c] && entValid[cplIdx[c]]) begin
          entDone[cplIdx[c]]  <= 1'b1;
          entFault[cplIdx[c]] <= cplFault[c];
          codeQ[cplIdx[c]]    <= cplCode[c];
          physRf[ptagQ[cplIdx[c]]] <= cplData[c];
        end
      end
      // allocation at the tail
      if (strobe.alloc) begin
        for (int k = 0; k < DISP_W; k++) begin
          if (k < int'(allocCnt)) begin
            entValid[allocSlot[k]] <= 1'b1;
            entDone[allocSlot[k]]  <= 1'b0;
            entFault[allocSlot[k]] <= 1'b0;
            archQ[allocSlot[k]]    <= dispArch[k];
            ptagQ[allocSlot[k]]    <= dispPtag[k];
          end
        end
      end
      // discard speculative entries
      if (strobe.flush || strobe.squash) begin
        for (int i = 0; i < DEPTH; i++)
          if (killMask[i]) entValid[i] <= 1'b0;
      end
      // commit: rename back into the architectural file, oldest first
      for (int k = 0; k < DISP_W; k++) begin
        if (k < int'(retireCnt)) begin
          archRf[archQ[retSlot[k]]] <= physRf[ptagQ[retSlot[k]]];
          entValid[retSlot[k]]      <= 1'b0;
        end
      end
    end
  end

  // R4
  arch_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (retireCnt == '0) |=> $stable(archRf));

  // R7
  flush_no_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flush |=> $stable(archRf));

endmodule

// File: rtl/rob_top.sv
module rob_top
  import rob_pkg::*;
#(
  parameter int DISP_W    = 4,
  parameter int DEPTH     = 16,
  parameter int ARCH_REGS = 16,
  parameter int PHYS_REGS = 32,
  parameter int DATA_W    = 32,
  parameter int FAULT_W   = 4,
  parameter int CPL_N     = 2,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = $clog2(DISP_W + 1),
  localparam int AW = $clog2(ARCH_REGS),
  localparam int PW = $clog2(PHYS_REGS)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [CW-1:0]                 dispCount,
  input  logic [DISP_W-1:0][AW-1:0]     dispArch,
  input  logic [DISP_W-1:0][PW-1:0]     dispPtag,
  output logic                          dispReady,
  output logic [IW-1:0]                 allocIdx,
  input  logic [CPL_N-1:0]              cplValid,
  input  logic [CPL_N-1:0][IW-1:0]      cplIdx,
  input  logic [CPL_N-1:0][DATA_W-1:0]  cplData,
  input  logic [CPL_N-1:0]              cplFault,
  input  logic [CPL_N-1:0][FAULT_W-1:0] cplCode,
  input  logic                          mispValid,
  input  logic [IW-1:0]                 mispIdx,
  output logic [CW-1:0]                 retCount,
  output logic                          excValid,
  output logic [IW-1:0]                 excIdx,
  output logic [FAULT_W-1:0]            excCode,
  input  logic [AW-1:0]                 archRdAddr,
  output logic [DATA_W-1:0]             archRdData
);

  robStrobe_t         strobe;
  logic [IW-1:0]      allocBase, headIdx;
  logic [CW-1:0]      allocCnt, retireCnt;
  logic [DEPTH-1:0]   killMask, entValid, entDone, entFault;
  logic [FAULT_W-1:0] headCode;

  assign allocIdx = allocBase;

  rob_ctrl #(.DISP_W(DISP_W), .DEPTH(DEPTH), .FAULT_W(FAULT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .dispCount(dispCount),
    .mispValid(mispValid), .mispIdx(mispIdx),
    .entValid(entValid), .entDone(entDone), .entFault(entFault), .headCode(headCode),
    .strobe(strobe), .allocBase(allocBase), .allocCnt(allocCnt),
    .retireCnt(retireCnt), .headIdx(headIdx), .killMask(killMask),
    .dispReady(dispReady), .retCountQ(retCount),
    .excValidQ(excValid), .excIdxQ(excIdx), .excCodeQ(excCode)
  );

  rob_data #(.DISP_W(DISP_W), .DEPTH(DEPTH), .ARCH_REGS(ARCH_REGS),
             .PHYS_REGS(PHYS_REGS), .DATA_W(DATA_W), .FAULT_W(FAULT_W),
             .CPL_N(CPL_N)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .allocBase(allocBase), .allocCnt(allocCnt),
    .dispArch(dispArch), .dispPtag(dispPtag),
    .retireCnt(retireCnt), .headIdx(headIdx), .killMask(killMask),
    .cplValid(cplValid), .cplIdx(cplIdx), .cplData(cplData),
    .cplFault(cplFault), .cplCode(cplCode),
    .archRdAddr(archRdAddr), .archRdData(archRdData),
    .entValid(entValid), .entDone(entDone), .entFault(entFault),
    .headCode(headCode)
  );

endmodule

// File: tb/rob_top_bench.sv
module rob_top_bench;

  localparam int DISP_W = 4;
  localparam int CPL_N  = 2;

  typedef struct packed {
    logic [31:0] idx;
    logic [31:0] data;
  } cplRow_t;

  // completion order for slots 0..7 (arch = slot+1), head slot last
  localparam cplRow_t TBL [8] = '{
    '{32'd5, 32'h0000_1505}, '{32'd7, 32'h0000_1707},
    '{32'd1, 32'h0000_1101}, '{32'd2, 32'h0000_1202},
    '{32'd3, 32'h0000_1303}, '{32'd6, 32'h0000_1606},
    '{32'd4, 32'h0000_1404}, '{32'd0, 32'h0000_1000}
  };

  logic clk = 1'b0;
  logic rstN;
  logic [2:0] dispCount;
  logic [DISP_W-1:0][3:0] dispArch;
  logic [DISP_W-1:0][4:0] dispPtag;
  logic dispReady;
  logic [3:0] allocIdx;
  logic [CPL_N-1:0] cplValid;
  logic [CPL_N-1:0][3:0] cplIdx;
  logic [CPL_N-1:0][31:0] cplData;
  logic [CPL_N-1:0] cplFault;
  logic [CPL_N-1:0][3:0] cplCode;
  logic mispValid;
  logic [3:0] mispIdx;
  logic [2:0] retCount;
  logic excValid;
  logic [3:0] excIdx;
  logic [3:0] excCode;
  logic [3:0] archRdAddr;
  logic [31:0] archRdData;

  int nTests = 0;
  int nFail = 0;

  always #10 clk = ~clk;

  rob_top u_rob_top (
    .clk(clk), .rstN(rstN), .dispCount(dispCount), .dispArch(dispArch),
    .dispPtag(dispPtag), .dispReady(dispReady), .allocIdx(allocIdx),
    .cplValid(cplValid), .cplIdx(cplIdx), .cplData(cplData),
    .cplFault(cplFault), .cplCode(cplCode), .mispValid(mispValid),
    .mispIdx(mispIdx), .retCount(retCount), .excValid(excValid),
    .excIdx(excIdx), .excCode(excCode), .archRdAddr(archRdAddr),
    .archRdData(archRdData)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic archIs(input string tag, input int r, input logic [31:0] exp);
    archRdAddr = 4'(r);
    #1;
    chk(tag, archRdData, exp);
  endtask

  task automatic dispGroup(input int n, input int a0, input int step, input int p0,
                           output int base);
    dispCount = 3'(n);
    for (int k = 0; k < DISP_W; k++) begin
      dispArch[k] = 4'(a0 + k * step);
      dispPtag[k] = 5'(p0 + k);
    end
    #1;
    base = int'(allocIdx);
    tick();
    dispCount = '0;
  endtask

  task automatic cpl(input int idx, input logic [31:0] data, input logic flt,
                     input logic [3:0] code);
    cplValid[0] = 1'b1; cplIdx[0] = 4'(idx); cplData[0] = data;
    cplFault[0] = flt;  cplCode[0] = code;
    tick();
    cplValid = '0; cplFault = '0;
  endtask

  task automatic cplPair(input int i0, input logic [31:0] d0,
                         input int i1, input logic [31:0] d1);
    cplValid = 2'b11;
    cplIdx[0] = 4'(i0); cplData[0] = d0;
    cplIdx[1] = 4'(i1); cplData[1] = d1;
    cplFault = '0;
    tick();
    cplValid = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    int base;
    rstN = 1'b0; dispCount = '0; dispArch = '0; dispPtag = '0;
    cplValid = '0; cplIdx = '0; cplData = '0; cplFault = '0; cplCode = '0;
    mispValid = 1'b0; mispIdx = '0; archRdAddr = '0;
    repeat (3) tick();
    rstN = 1'b1;
    tick();

    // R1 reset state
    dispCount = 3'd4; #1;
    chk("R1 ready", {31'd0, dispReady}, 32'd1);
    chk("R1 allocIdx", {28'd0, allocIdx}, 32'd0);
    dispCount = '0;
    chk("R1 excValid", {31'd0, excValid}, 32'd0);
    chk("R1 retCount", {29'd0, retCount}, 32'd0);
    archIs("R1 arch3", 3, 32'd0);

    // R2 two groups of four: slots 0..7, arch = slot+1
    dispGroup(4, 1, 1, 1, base);
    chk("R2 base0", base, 32'd0);
    dispGroup(4, 5, 1, 5, base);
    chk("R2 base1", base, 32'd4);

    // table walk: out-of-order completion, head last (R5, R4)
    for (int i = 0; i < 8; i++) begin
      cpl(int'(TBL[i].idx), TBL[i].data, 1'b0, 4'd0);
      chk("R5 no retire before head", {29'd0, retCount}, 32'd0);
      if (TBL[i].idx == 32'd1) archIs("R4 arch2 held", 2, 32'd0);
    end
    tick();
    chk("R6 first group", {29'd0, retCount}, 32'd4);
    tick();
    chk("R6 second group", {29'd0, retCount}, 32'd4);
    tick();
    chk("R6 idle", {29'd0, retCount}, 32'd0);
    for (int i = 0; i < 8; i++)
      archIs("R4 committed value", int'(TBL[i].idx) + 1, TBL[i].data);

    // R3 fill all 16 slots starting at slot 8
    dispGroup(4, 9, 1, 9, base);
    chk("R2 base8", base, 32'd8);
    dispGroup(4, 12, 1, 13, base);
    chk("R2 base12", base, 32'd12);
    dispGroup(4, 12, 1, 17, base);
    chk("R2 wrap base0", base, 32'd0);
    dispGroup(4, 12, 1, 21, base);
    chk("R2 base4", base, 32'd4);
    dispCount = 3'd1; #1;
    chk("R3 full not ready", {31'd0, dispReady}, 32'd0);
    tick();
    #1;
    chk("R3 refused group", {31'd0, dispReady}, 32'd0);
    dispCount = '0;

    // R8 / R9 mispredict at slot 10 with a dispatch offered
    mispValid = 1'b1; mispIdx = 4'd10; dispCount = 3'd1;
    tick();
    mispValid = 1'b0; #1;
    chk("R9 dispatch dropped", {28'd0, allocIdx}, 32'd11);
    chk("R8 ready after squash", {31'd0, dispReady}, 32'd1);
    dispCount = '0;
    cpl(11, 32'hDEAD_0011, 1'b0, 4'd0);
    dispGroup(1, 5, 1, 25, base);
    chk("R8 tail after branch", base, 32'd11);
    cpl(11, 32'h55, 1'b0, 4'd0);
    cpl(10, 32'h44, 1'b0, 4'd0);
    cpl(9, 32'h33, 1'b0, 4'd0);
    cpl(8, 32'h22, 1'b0, 4'd0);
    tick();
    chk("R6 four at once", {29'd0, retCount}, 32'd4);
    tick();
    archIs("R8 arch9", 9, 32'h22);
    archIs("R8 arch10", 10, 32'h33);
    archIs("R8 arch11", 11, 32'h44);
    archIs("R8 arch5 new", 5, 32'h55);
    archIs("R8 squashed arch12", 12, 32'd0);

    // R7 deferred fault on slot 14
    dispGroup(4, 1, 1, 26, base);
    chk("R2 base12 again", base, 32'd12);
    cpl(14, 32'hBAD, 1'b1, 4'd5);
    tick();
    chk("R7 fault deferred", {31'd0, excValid}, 32'd0);
    cpl(15, 32'h66, 1'b0, 4'd0);
    cpl(13, 32'h77, 1'b0, 4'd0);
    cpl(12, 32'h88, 1'b0, 4'd0);
    tick();
    chk("R7 older retire", {29'd0, retCount}, 32'd2);
    chk("R7 not yet", {31'd0, excValid}, 32'd0);
    tick();
    chk("R7 excValid", {31'd0, excValid}, 32'd1);
    chk("R7 excIdx", {28'd0, excIdx}, 32'd14);
    chk("R7 excCode", {28'd0, excCode}, 32'd5);
    chk("R7 no retire with fault", {29'd0, retCount}, 32'd0);
    archIs("R7 arch1", 1, 32'h88);
    archIs("R7 arch2", 2, 32'h77);
    archIs("R7 arch3 kept", 3, TBL[3].data);
    archIs("R7 arch4 kept", 4, TBL[4].data);
    tick();
    chk("R7 single pulse", {31'd0, excValid}, 32'd0);
    dispCount = 3'd4; #1;
    chk("R7 empty ready", {31'd0, dispReady}, 32'd1);
    chk("R7 tail at fault", {28'd0, allocIdx}, 32'd14);
    dispCount = '0;

    // R10 / R11 one group all writing arch 7, slots 14,15,0,1
    dispGroup(4, 7, 0, 1, base);
    chk("R2 base14", base, 32'd14);
    cplPair(1, 32'h101, 0, 32'h100);
    cplPair(15, 32'h115, 14, 32'h114);
    tick();
    chk("R11 both ports", {29'd0, retCount}, 32'd4);
    archIs("R10 youngest wins", 7, 32'h101);

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule